// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block sits between a processor bus and the two serial channels of an asynchronous serial controller. The processor bus has an 8-bit data path, a 4-bit address, an active-low chip select and separate active-low read and write strobes, all synchronous to the block clock. The block decodes each address one way for reads and another way for writes. It holds the writable configuration registers and turns command writes into single-cycle control pulses for the serial engines. A few addresses act as commands when they are accessed and hold no data. Status, receive data, counter values and input pins come from the surrounding logic as plain inputs.

Each channel has two mode registers that share one address. A hidden per-channel pointer picks which one an access reaches. The first access to the address after reset reaches the first mode register and moves the pointer to the second mode register. The pointer stays there until reset or until a pointer-reset command. The read data path is only driven while a read is in progress. Otherwise the enable is low and the data is zero, so an outer pad ring can tri-state the bus.

Top module: `duh_host_regs`

## Requirements
- R1: `rdata_oe` is high only while `cs_n` and `rd_n` are both low. While `rdata_oe` is low, `rdata` is zero.
- R2: A write takes effect at the first clock edge at which the write strobe (`wr_n` low with `cs_n` low) has been released. It uses the address and data held during the last strobe-active cycle, and stored outputs do not change while the strobe is still held.
- R3: Address 0 (channel A) and address 8 (channel B) reach the first mode register while the channel's pointer is 0 and the second mode register while it is 1. Reset sets both pointers to 0, and any completed read or write of the address sets the pointer to 1.
- R4: A command write whose bits 7:4 equal 4'h1 returns that channel's mode pointer to 0.
- R5: Reads of addresses 1 and 9 return `sr_in` of channel A and B. Writes to them load `csr_out` of the channel.
- R6: Reads of addresses 3 and 11 return `rhr_in` of the channel. Writes to them pulse `thr_load` of the channel for one cycle and place the byte on `thr_data`.
- R7: A write to address 2 (A) or 10 (B) pulses, for one cycle, `rx_enable` if bit 0 is set, `rx_disable` if bit 1 is set, `tx_enable` if bit 2 is set and `tx_disable` if bit 3 is set. If bits 7:4 are non-zero, it also pulses `misc_valid` with `misc_code` equal to those bits. `misc_code` is zero otherwise.
- R8: The start of a read of address 14 pulses `ct_start` for one cycle, and the start of a read of address 15 pulses `ct_stop` for one cycle. Both reads return zero.
- R9: A write to address 13 loads `opcr_out`. A write to 14 sets the output-port bits selected by the data, and a write to 15 clears them. `op_pins` is the bitwise inverse of the output-port register.
- R10: After reset, `op_pins` is 8'hFF, both mode pointers are 0, and all stored registers (mode, clock select, auxiliary, interrupt mask, counter preset, output port, output port configuration, transmit data) are zero.
- R11: Address 12 is reserved. Reads return zero and writes change no output. Reads of the test addresses 2 and 10 also return zero.
- R12: Writes to addresses 4, 5, 6 and 7 load `acr_out`, `imr_out` and the upper and lower bytes of `ct_preset_out`. Reads of 4, 5, 6, 7 and 13 return `ipcr_in`, `isr_in`, `ctu_in`, `ctl_in` and {1'b0, `ip_in`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |
| sr_in | input | 2x8 | Channel status bytes |
| rhr_in | input | 2x8 | Channel receive data bytes |
| ipcr_in | input | 8 | Input change byte |
| isr_in | input | 8 | Interrupt status byte |
| ctu_in | input | 8 | Counter value, upper byte |
| ctl_in | input | 8 | Counter value, lower byte |
| ip_in | input | 7 | Input pins |
| mr1_out | output | 2x8 | First mode register per channel |
| mr2_out | output | 2x8 | Second mode register per channel |
| csr_out | output | 2x8 | Clock select per channel |
| acr_out | output | 8 | Auxiliary control |
| imr_out | output | 8 | Interrupt mask |
| ct_preset_out | output | 16 | Counter preset |
| opcr_out | output | 8 | Output port configuration |
| op_pins | output | 8 | Output port pins, active low |
| tx_enable | output | 2 | Transmitter enable pulse per channel |
| tx_disable | output | 2 | Transmitter disable pulse per channel |
| rx_enable | output | 2 | Receiver enable pulse per channel |
| rx_disable | output | 2 | Receiver disable pulse per channel |
| misc_valid | output | 2 | Miscellaneous command pulse per channel |
| misc_code | output | 2x4 | Miscellaneous command code per channel |
| thr_load | output | 2 | Transmit data load pulse per channel |
| thr_data | output | 8 | Last transmit byte written |
| ct_start | output | 1 | Counter start pulse |
| ct_stop | output | 1 | Counter stop pulse |

## Verification
Random reads and writes over all sixteen addresses, with fresh random input bytes for every access, tell a swapped read map apart from a swapped write map. This works because each address is compared on both sides against a bench model. Directed write, write, read sequences on the shared mode address, followed by a pointer-reset command, separate a pointer that never advances, one that toggles, and one that ignores the command. Set and clear masks with overlapping bits show whether the output port is set, cleared or overwritten. Writes to the reserved address, and read strobes with the chip select high, show whether such accesses leak into stored state or into the counter pulses.

// File: rtl/duh_pkg.sv
// Shared types and constants for the host register front end.
// Assumes an 8-bit bus and a 4-bit address; the address map is fixed by behaviour.
package duh_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int NUM_CH = 2;
    localparam int MISC_W = 4;

    // Mode register pointer state
    typedef enum logic {
        PTR_MR1 = 1'b0,
        PTR_MR2 = 1'b1
    } mr_ptr_e;

    // Low two address bits inside a channel window (address bit 2 low)
    localparam logic [1:0] LOC_MODE = 2'd0;
    localparam logic [1:0] LOC_CLK  = 2'd1;
    localparam logic [1:0] LOC_CMD  = 2'd2;
    localparam logic [1:0] LOC_HOLD = 2'd3;

    // Miscellaneous command code that rewinds the mode pointer
    localparam logic [MISC_W-1:0] MISC_PTR_RST = 4'h1;

    // Shared-register write addresses
    localparam logic [ADDR_W-1:0] WA_ACR  = 4'd4;
    localparam logic [ADDR_W-1:0] WA_IMR  = 4'd5;
    localparam logic [ADDR_W-1:0] WA_CTU  = 4'd6;
    localparam logic [ADDR_W-1:0] WA_CTL  = 4'd7;
    localparam logic [ADDR_W-1:0] WA_OPCR = 4'd13;
    localparam logic [ADDR_W-1:0] WA_OSET = 4'd14;
    localparam logic [ADDR_W-1:0] WA_OCLR = 4'd15;

    // Access-triggered read commands
    localparam logic [ADDR_W-1:0] RA_CT_GO   = 4'd14;
    localparam logic [ADDR_W-1:0] RA_CT_HALT = 4'd15;
endpackage

// File: rtl/duh_bus_sync.sv
// Strobe tracker: turns the level-sensitive bus strobes into single-cycle events.
// Assumes cs_n, rd_n, wr_n, addr and wdata are already synchronous to clk.
// A write fires when the strobe is released; a read has a start and an end event.
module duh_bus_sync #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_active,
    output logic          rd_begin,
    output logic          rd_done,
    output logic [AW-1:0] rd_addr_done
);
    logic wr_now;
    logic wr_q;
    logic rd_q;
    logic [AW-1:0] rd_addr_q;

    // Current strobe levels qualified by chip select
    always_comb begin
        wr_now    = !cs_n && !wr_n;
        rd_active = !cs_n && !rd_n;
    end

    // Remember last cycle's strobe state and capture address and data while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            rd_q      <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_addr_q <= '0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_active;
            if (wr_now) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
            if (rd_active) begin
                rd_addr_q <= addr;
            end
        end
    end

    // Edge events derived from the level history
    always_comb begin
        wr_fire      = wr_q && !wr_now;
        rd_begin     = rd_active && !rd_q;
        rd_done      = rd_q && !rd_active;
        rd_addr_done = rd_addr_q;
    end
endmodule

// File: rtl/duh_chan.sv
// Per-channel register slice: two mode registers behind one pointer, clock select,
// and decode of command and transmit-data writes into one-cycle pulses.
// Assumes wr_hit is a one-cycle write event already decoded to this channel.
module duh_chan
    import duh_pkg::*;
#(
    parameter int DW = 8,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [1:0]    wr_loc,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_mode_done,
    output logic [DW-1:0] mr1_q,
    output logic [DW-1:0] mr2_q,
    output logic [DW-1:0] csr_q,
    output mr_ptr_e       ptr_q,
    output logic          rx_en_p,
    output logic          rx_dis_p,
    output logic          tx_en_p,
    output logic          tx_dis_p,
    output logic          misc_v_p,
    output logic [MW-1:0] misc_p,
    output logic          thr_ld_p
);
    localparam int MISC_LO = DW - MW;

    logic wr_mode;
    logic wr_clk;
    logic wr_cmd;
    logic wr_hold;
    logic ptr_rewind;
    logic [MW-1:0] misc_field;

    // Decode the write event into this channel's locations
    always_comb begin
        wr_mode    = wr_hit && (wr_loc == LOC_MODE);
        wr_clk     = wr_hit && (wr_loc == LOC_CLK);
        wr_cmd     = wr_hit && (wr_loc == LOC_CMD);
        wr_hold    = wr_hit && (wr_loc == LOC_HOLD);
        misc_field = wr_data[DW-1:MISC_LO];
        ptr_rewind = wr_cmd && (misc_field == MISC_PTR_RST);
    end

    // Mode pointer: advance on any mode access, rewind on the pointer-reset command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_MR1;
        end else if (ptr_rewind) begin
            ptr_q <= PTR_MR1;
        end else if (wr_mode || rd_mode_done) begin
            ptr_q <= PTR_MR2;
        end
    end

    // Mode and clock select storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr1_q <= '0;
            mr2_q <= '0;
            csr_q <= '0;
        end else begin
            if (wr_mode && ptr_q == PTR_MR1) mr1_q <= wr_data;
            if (wr_mode && ptr_q == PTR_MR2) mr2_q <= wr_data;
            if (wr_clk) csr_q <= wr_data;
        end
    end

    // Command and transmit-data pulses, one cycle each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_p  <= 1'b0;
            rx_dis_p <= 1'b0;
            tx_en_p  <= 1'b0;
            tx_dis_p <= 1'b0;
            misc_v_p <= 1'b0;
            misc_p   <= '0;
            thr_ld_p <= 1'b0;
        end else begin
            rx_en_p  <= wr_cmd && wr_data[0];
            rx_dis_p <= wr_cmd && wr_data[1];
            tx_en_p  <= wr_cmd && wr_data[2];
            tx_dis_p <= wr_cmd && wr_data[3];
            misc_v_p <= wr_cmd && (misc_field != '0);
            misc_p   <= wr_cmd ? misc_field : '0;
            thr_ld_p <= wr_hold;
        end
    end
endmodule

// File: rtl/duh_common.sv
// Shared registers: auxiliary control, interrupt mask, counter preset, output port
// and its configuration, transmit byte, and the counter start/stop read commands.
// Assumes wr_fire is a one-cycle write event and rd_begin marks the first read cycle.
module duh_common
    import duh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_fire,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_begin,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   acr_q,
    output logic [DW-1:0]   imr_q,
    output logic [2*DW-1:0] ct_preset_q,
    output logic [DW-1:0]   opcr_q,
    output logic [DW-1:0]   opr_q,
    output logic [DW-1:0]   thr_q,
    output logic            ct_go_p,
    output logic            ct_halt_p
);
    logic hold_hit;

    // A transmit-data write of either channel: address bit 2 low, low bits at HOLD
    always_comb hold_hit = wr_fire && !wr_addr[2] && (wr_addr[1:0] == LOC_HOLD);

    // Plain storage registers on the shared side of the map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acr_q       <= '0;
            imr_q       <= '0;
            ct_preset_q <= '0;
            opcr_q      <= '0;
            thr_q       <= '0;
        end else if (wr_fire) begin
            if (wr_addr == WA_ACR)  acr_q <= wr_data;
            if (wr_addr == WA_IMR)  imr_q <= wr_data;
            if (wr_addr == WA_CTU)  ct_preset_q[2*DW-1:DW] <= wr_data;
            if (wr_addr == WA_CTL)  ct_preset_q[DW-1:0] <= wr_data;
            if (wr_addr == WA_OPCR) opcr_q <= wr_data;
            if (hold_hit)           thr_q <= wr_data;
        end
    end

    // Output port register: masked set and masked clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opr_q <= '0;
        end else if (wr_fire && wr_addr == WA_OSET) begin
            opr_q <= opr_q | wr_data;
        end else if (wr_fire && wr_addr == WA_OCLR) begin
            opr_q <= opr_q & ~wr_data;
        end
    end

    // Counter start/stop pulses issued at the start of a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_go_p   <= 1'b0;
            ct_halt_p <= 1'b0;
        end else begin
            ct_go_p   <= rd_begin && (rd_addr == RA_CT_GO);
            ct_halt_p <= rd_begin && (rd_addr == RA_CT_HALT);
        end
    end
endmodule

// File: rtl/duh_host_regs.sv
// Top of the host register front end: strobe tracking, two channel slices,
// the shared registers and the read multiplexer.
// Assumes bus signals are synchronous to clk; the read path is combinational.
module duh_host_regs
    import duh_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NC = NUM_CH,
    parameter int MW = MISC_W,
    parameter int IPW = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    output logic                   rdata_oe,
    input  logic [NC-1:0][DW-1:0]  sr_in,
    input  logic [NC-1:0][DW-1:0]  rhr_in,
    input  logic [DW-1:0]          ipcr_in,
    input  logic [DW-1:0]          isr_in,
    input  logic [DW-1:0]          ctu_in,
    input  logic [DW-1:0]          ctl_in,
    input  logic [IPW-1:0]         ip_in,
    output logic [NC-1:0][DW-1:0]  mr1_out,
    output logic [NC-1:0][DW-1:0]  mr2_out,
    output logic [NC-1:0][DW-1:0]  csr_out,
    output logic [DW-1:0]          acr_out,
    output logic [DW-1:0]          imr_out,
    output logic [2*DW-1:0]        ct_preset_out,
    output logic [DW-1:0]          opcr_out,
    output logic [DW-1:0]          op_pins,
    output logic [NC-1:0]          tx_enable,
    output logic [NC-1:0]          tx_disable,
    output logic [NC-1:0]          rx_enable,
    output logic [NC-1:0]          rx_disable,
    output logic [NC-1:0]          misc_valid,
    output logic [NC-1:0][MW-1:0]  misc_code,
    output logic [NC-1:0]          thr_load,
    output logic [DW-1:0]          thr_data,
    output logic                   ct_start,
    output logic                   ct_stop
);
    localparam int CH_BIT = AW - 1;

    logic          wr_fire;
    logic [AW-1:0] wr_addr_c;
    logic [DW-1:0] wr_data_c;
    logic          rd_active;
    logic          rd_begin;
    logic          rd_done;
    logic [AW-1:0] rd_addr_done;
    logic [NC-1:0] chan_ptr;
    logic [NC-1:0][DW-1:0] mode_view;
    logic [DW-1:0] opr_q;
    logic [DW-1:0] rd_word;

    duh_bus_sync #(.AW(AW), .DW(DW)) i_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .addr         (addr),
        .wdata        (wdata),
        .wr_fire      (wr_fire),
        .wr_addr      (wr_addr_c),
        .wr_data      (wr_data_c),
        .rd_active    (rd_active),
        .rd_begin     (rd_begin),
        .rd_done      (rd_done),
        .rd_addr_done (rd_addr_done)
    );

    for (genvar g = 0; g < NC; g++) begin : g_ch
        logic hit_w;
        logic hit_rmode;
        mr_ptr_e ptr_e;

        // Channel g owns addresses with bit 2 low and the top bit equal to g
        always_comb begin
            hit_w     = wr_fire && !wr_addr_c[2] && (wr_addr_c[CH_BIT] == g[0]);
            hit_rmode = rd_done && !rd_addr_done[2] && (rd_addr_done[CH_BIT] == g[0])
                        && (rd_addr_done[1:0] == LOC_MODE);
            chan_ptr[g]  = ptr_e;
            mode_view[g] = (ptr_e == PTR_MR1) ? mr1_out[g] : mr2_out[g];
        end

        duh_chan #(.DW(DW), .MW(MW)) i_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_hit       (hit_w),
            .wr_loc       (wr_addr_c[1:0]),
            .wr_data      (wr_data_c),
            .rd_mode_done (hit_rmode),
            .mr1_q        (mr1_out[g]),
            .mr2_q        (mr2_out[g]),
            .csr_q        (csr_out[g]),
            .ptr_q        (ptr_e),
            .rx_en_p      (rx_enable[g]),
            .rx_dis_p     (rx_disable[g]),
            .tx_en_p      (tx_enable[g]),
            .tx_dis_p     (tx_disable[g]),
            .misc_v_p     (misc_valid[g]),
            .misc_p       (misc_code[g]),
            .thr_ld_p     (thr_load[g])
        );
    end

    duh_common #(.AW(AW), .DW(DW)) i_common (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr_c),
        .wr_data     (wr_data_c),
        .rd_begin    (rd_begin),
        .rd_addr     (addr),
        .acr_q       (acr_out),
        .imr_q       (imr_out),
        .ct_preset_q (ct_preset_out),
        .opcr_q      (opcr_out),
        .opr_q       (opr_q),
        .thr_q       (thr_data),
        .ct_go_p     (ct_start),
        .ct_halt_p   (ct_stop)
    );

    // Output pins are active low: a set register bit pulls its pin low
    always_comb op_pins = ~opr_q;

    // Read-side address map
    always_comb begin
        rd_word = '0;
        case (addr)
            4'd0:    rd_word = mode_view[0];
            4'd1:    rd_word = sr_in[0];
            4'd3:    rd_word = rhr_in[0];
            4'd4:    rd_word = ipcr_in;
            4'd5:    rd_word = isr_in;
            4'd6:    rd_word = ctu_in;
            4'd7:    rd_word = ctl_in;
            4'd8:    rd_word = mode_view[1];
            4'd9:    rd_word = sr_in[1];
            4'd11:   rd_word = rhr_in[1];
            4'd13:   rd_word = {{(DW-IPW){1'b0}}, ip_in};
            default: rd_word = '0;
        endcase
    end

    // Drive the read data only during an active read
    always_comb begin
        rdata_oe = rd_active;
        rdata    = rd_active ? rd_word : '0;
    end
endmodule

// File: rtl/duh_host_regs_chk.sv
// Property checker for the host register front end, attached by bind.
// Assumes two channels and the fixed address map of the top module.
module duh_host_regs_chk #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NC = 2,
    parameter int MW = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic [DW-1:0]         rdata,
    input logic                  rdata_oe,
    input logic                  wr_fire,
    input logic [AW-1:0]         wr_addr,
    input logic [NC-1:0]         chan_ptr,
    input logic [NC-1:0]         misc_valid,
    input logic [NC-1:0][MW-1:0] misc_code,
    input logic [NC-1:0]         tx_enable,
    input logic [NC-1:0]         rx_enable,
    input logic [DW-1:0]         op_pins,
    input logic [DW-1:0]         opcr_out,
    input logic [DW-1:0]         acr_out,
    input logic [DW-1:0]         imr_out,
    input logic                  ct_start,
    input logic                  ct_stop
);
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!rdata_oe && rdata == '0));

    a_r8_ct_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_start || ct_stop) |=> !(ct_start || ct_stop));

    a_r8_ct_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ct_start && ct_stop));

    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr == 4'd12) |=> ($stable(op_pins) && $stable(opcr_out)
            && $stable(acr_out) && $stable(imr_out)));

    a_r9_pins_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(op_pins));

    for (genvar g = 0; g < NC; g++) begin : g_chk
        a_r7_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_enable[g] || rx_enable[g]) |=> !(tx_enable[g] || rx_enable[g]));

        a_r4_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(chan_ptr[g]) && !chan_ptr[g])
                |-> (misc_valid[g] && misc_code[g] == 4'h1));
    end
endmodule

bind duh_host_regs duh_host_regs_chk #(.AW(AW), .DW(DW), .NC(NC), .MW(MW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr_c),
    .chan_ptr   (chan_ptr),
    .misc_valid (misc_valid),
    .misc_code  (misc_code),
    .tx_enable  (tx_enable),
    .rx_enable  (rx_enable),
    .op_pins    (op_pins),
    .opcr_out   (opcr_out),
    .acr_out    (acr_out),
    .imr_out    (imr_out),
    .ct_start   (ct_start),
    .ct_stop    (ct_stop)
);

// File: tb/test_duh_host_regs.sv
// Bench for the host register front end: directed corner cases, then seeded random
// accesses compared against a behavioural model kept in bench variables.
module test_duh_host_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_oe;
    logic [1:0][7:0] sr_in = '0, rhr_in = '0;
    logic [7:0] ipcr_in = '0, isr_in = '0, ctu_in = '0, ctl_in = '0;
    logic [6:0] ip_in = '0;
    logic [1:0][7:0] mr1_out, mr2_out, csr_out;
    logic [7:0] acr_out, imr_out, opcr_out, op_pins, thr_data;
    logic [15:0] ct_preset_out;
    logic [1:0] tx_enable, tx_disable, rx_enable, rx_disable, misc_valid, thr_load;
    logic [1:0][3:0] misc_code;
    logic ct_start, ct_stop;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Model state
    logic [1:0][7:0] m_mr1 = '0, m_mr2 = '0, m_csr = '0;
    logic [1:0] m_ptr = '0;
    logic [7:0] m_acr = '0, m_imr = '0, m_opcr = '0, m_opr = '0, m_thr = '0;
    logic [15:0] m_ctp = '0;

    // Pulse snapshot taken right after the commit edge
    logic [1:0] s_txe, s_txd, s_rxe, s_rxd, s_mv, s_thl;
    logic [1:0][3:0] s_mc;

    always #10 clk = ~clk;

    duh_host_regs i_duh_host_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .sr_in(sr_in), .rhr_in(rhr_in), .ipcr_in(ipcr_in), .isr_in(isr_in),
        .ctu_in(ctu_in), .ctl_in(ctl_in), .ip_in(ip_in),
        .mr1_out(mr1_out), .mr2_out(mr2_out), .csr_out(csr_out),
        .acr_out(acr_out), .imr_out(imr_out), .ct_preset_out(ct_preset_out),
        .opcr_out(opcr_out), .op_pins(op_pins),
        .tx_enable(tx_enable), .tx_disable(tx_disable),
        .rx_enable(rx_enable), .rx_disable(rx_disable),
        .misc_valid(misc_valid), .misc_code(misc_code),
        .thr_load(thr_load), .thr_data(thr_data),
        .ct_start(ct_start), .ct_stop(ct_stop)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected read value from the read-side map (R5, R6, R8, R11, R12, R3)
    function automatic logic [7:0] f_read(input logic [3:0] a);
        case (a)
            4'd0:  f_read = m_ptr[0] ? m_mr2[0] : m_mr1[0];
            4'd1:  f_read = sr_in[0];
            4'd3:  f_read = rhr_in[0];
            4'd4:  f_read = ipcr_in;
            4'd5:  f_read = isr_in;
            4'd6:  f_read = ctu_in;
            4'd7:  f_read = ctl_in;
            4'd8:  f_read = m_ptr[1] ? m_mr2[1] : m_mr1[1];
            4'd9:  f_read = sr_in[1];
            4'd11: f_read = rhr_in[1];
            4'd13: f_read = {1'b0, ip_in};
            default: f_read = 8'h00;
        endcase
    endfunction

    // Compare every stored output against the model
    task automatic chk_state(input string req);
        chk({req, " mr1"}, 32'(mr1_out), 32'(m_mr1));
        chk({req, " mr2"}, 32'(mr2_out), 32'(m_mr2));
        chk({req, " csr"}, 32'(csr_out), 32'(m_csr));
        chk({req, " acr/imr"}, {16'h0, acr_out, imr_out}, {16'h0, m_acr, m_imr});
        chk({req, " ctp"}, 32'(ct_preset_out), 32'(m_ctp));
        chk({req, " opcr/pins"}, {16'h0, opcr_out, op_pins}, {16'h0, m_opcr, ~m_opr});
        chk({req, " thr"}, 32'(thr_data), 32'(m_thr));
    endtask

    // Full write cycle; checks the strobe-held state (R2) and the pulses (R6, R7)
    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        int ch;
        logic is_cmd, is_hold;
        ch = int'(a[3]);
        is_cmd  = !a[2] && a[1:0] == 2'd2;
        is_hold = !a[2] && a[1:0] == 2'd3;
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        tick();
        chk_state("R2 held");
        wr_n = 1'b1;
        tick();
        s_txe = tx_enable; s_txd = tx_disable; s_rxe = rx_enable; s_rxd = rx_disable;
        s_mv = misc_valid; s_mc = misc_code; s_thl = thr_load;
        cs_n = 1'b1;
        // Model update
        if (!a[2]) begin
            case (a[1:0])
                2'd0: begin
                    if (m_ptr[ch]) m_mr2[ch] = d; else m_mr1[ch] = d;
                    m_ptr[ch] = 1'b1;
                end
                2'd1: m_csr[ch] = d;
                2'd2: if (d[7:4] == 4'h1) m_ptr[ch] = 1'b0;
                default: m_thr = d;
            endcase
        end else begin
            case (a)
                4'd4:  m_acr = d;
                4'd5:  m_imr = d;
                4'd6:  m_ctp[15:8] = d;
                4'd7:  m_ctp[7:0] = d;
                4'd13: m_opcr = d;
                4'd14: m_opr = m_opr | d;
                4'd15: m_opr = m_opr & ~d;
                default: ;
            endcase
        end
        chk("R7 cmd pulses",
            {16'h0, s_rxe, s_rxd, s_txe, s_txd, s_mv, 6'h0},
            {16'h0,
             2'(is_cmd && d[0]) << ch, 2'(is_cmd && d[1]) << ch,
             2'(is_cmd && d[2]) << ch, 2'(is_cmd && d[3]) << ch,
             2'(is_cmd && d[7:4] != 4'h0) << ch, 6'h0});
        chk("R7 misc code", 32'(s_mc), is_cmd ? (32'(d[7:4]) << (4 * ch)) : 32'h0);
        chk("R6 thr pulse", 32'(s_thl), 32'(2'(is_hold) << ch));
        tick();
        chk_state("R12 after write");
    endtask

    // Full read cycle; checks data (map), enable (R1) and counter pulses (R8)
    task automatic do_read(input logic [3:0] a, input string req);
        logic [7:0] exp;
        exp = f_read(a);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        chk({req, " rdata"}, 32'(rdata), 32'(exp));
        chk("R1 oe during read", 32'(rdata_oe), 32'h1);
        tick();
        chk("R8 ct pulses", {30'h0, ct_start, ct_stop},
            {30'h0, a == 4'd14, a == 4'd15});
        rd_n = 1'b1;
        tick();
        cs_n = 1'b1;
        if (a == 4'd0) m_ptr[0] = 1'b1;
        if (a == 4'd8) m_ptr[1] = 1'b1;
        tick();
        chk("R1 oe idle", {31'h0, rdata_oe}, 32'h0);
    endtask

    task automatic randomize_inputs();
        sr_in = {8'($urandom), 8'($urandom)};
        rhr_in = {8'($urandom), 8'($urandom)};
        ipcr_in = 8'($urandom); isr_in = 8'($urandom);
        ctu_in = 8'($urandom); ctl_in = 8'($urandom);
        ip_in = 7'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R10: reset state
        chk("R10 pins", 32'(op_pins), 32'hFF);
        chk_state("R10 reset");
        randomize_inputs();
        do_read(4'd0, "R3 ptr after reset");
        do_read(4'd0, "R3 second read");
        // R3/R4: pointer on channel B with writes and rewind
        do_write(4'd8, 8'h11);
        chk("R3 first write to MR1", 32'(mr1_out[1]), 32'h11);
        do_write(4'd8, 8'h22);
        chk("R3 second write to MR2", 32'(mr2_out[1]), 32'h22);
        do_read(4'd8, "R3 read MR2");
        do_write(4'd10, 8'h15);
        do_read(4'd8, "R4 read MR1 after rewind");
        do_write(4'd2, 8'h1F);
        // R9: set and clear with overlap
        do_write(4'd14, 8'hF0);
        chk("R9 set", 32'(op_pins), 32'h0F);
        do_write(4'd15, 8'h30);
        chk("R9 clear", 32'(op_pins), 32'h3F);
        // R11: reserved address
        do_write(4'd12, 8'hA5);
        do_read(4'd12, "R11 reserved read");
        do_read(4'd2, "R11 test read");
        // R8: counter commands
        do_read(4'd14, "R8 start read");
        do_read(4'd15, "R8 stop read");
        // R1: read strobe with chip select high
        rd_n = 1'b0; addr = 4'd14;
        #1;
        chk("R1 no drive without cs", {31'h0, rdata_oe}, 32'h0);
        tick();
        chk("R1 no ct pulse without cs", {30'h0, ct_start, ct_stop}, 32'h0);
        rd_n = 1'b1;
        tick();
        // Random mix
        for (int i = 0; i < 400; i++) begin
            randomize_inputs();
            if ($urandom_range(1, 0) == 1) do_write(4'($urandom), 8'($urandom));
            else do_read(4'($urandom), "R12 random read");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule